// File: doc/BRIEF.md
# Chainable Periodic Downcounter Timer

This block is a 16-bit periodic downcounter that steps once per selected timer tick and restarts from a programmable period each time it runs out. It can also be coupled to a second 16-bit word, normally the upper watchdog count, so that the two words behave as one 32-bit downcounter. In that mode the low word never reloads. It wraps and borrows from the upper word instead.

Software programs two period words through one 32-bit write port with four byte enables. Counting begins only after the least significant byte of the low period has been written. The tick comes from one of six sources: the system or reference clock at half rate, or one of four taps of a free-running prescaler. The prescaler itself runs from either of the two half-rate clocks. Each time the low word arrives at zero, a sticky flag is set. When the interrupt enable is on and the interrupt level is non-zero, that flag raises an interrupt request.

The controller is a three-state machine. ST_IDLE does not count. ST_LOAD copies the period words into the counters for one cycle. ST_RUN decrements the counters on ticks. The transitions are:
- ARM: ST_IDLE to ST_LOAD, on a write that includes byte lane 0.
- START: ST_LOAD to ST_RUN, unconditional after one cycle.
- REARM: ST_RUN or ST_LOAD back to ST_LOAD, on another lane-0 write.
- RESET: any state to ST_IDLE, when either reset is asserted.

Top module: `chain_rtc_timer`

## Requirements
- R1: After power-on reset (`por_n` low), `count_o` reads 0, `zero_flag_o` and `irq_o` are 0, and both period words are 0.
- R2: A general reset (`rst_n` low, `por_n` high) clears `zero_flag_o` and returns the controller to ST_IDLE. It leaves `count_o` unchanged, and ticks after it do not move the count until the timer is armed again.
- R3: Ticks do not change `count_o` until a write with `wr_be[0]` set has occurred. Writes without byte lane 0 do not arm the timer. The counters load from the period words on the clock edge after the arming write, and a tick present on that load edge is ignored.
- R4: When `chain_en` is 0, each tick in ST_RUN decrements the low word `count_o[15:0]`. A tick that finds the low word at 0 reloads it from the low period, and the upper word `count_o[31:16]` is held.
- R5: When `chain_en` is 1, loading sets `count_o` to {high period, low period}. Each tick then decrements `count_o` as a single 32-bit value: the low word wraps from 0 to 0xFFFF and borrows one from the upper word, and 0 wraps to 0xFFFFFFFF. Both words are driven from one register, so a 32-bit read is coherent.
- R6: `zero_flag_o` is set by any tick after which the low word equals 0, and it stays set. It is cleared by a one-cycle pulse on `flag_clr`. If setting and clearing fall in the same cycle, setting wins.
- R7: `irq_o` is 1 exactly when `zero_flag_o` is 1, `irq_en` is 1 and `irq_lvl` is non-zero.
- R8: The tick source is chosen by `clk_sel`: 000 = `sys_half_tick`, 001 = `ref_half_tick`, 010 = prescaler/1024, 011 = /256, 100 = /64, 101 = /16, 110 and 111 = no ticks.
- R9: The prescaler counts pulses of `sys_half_tick` when `pre_src` = 0 and pulses of `ref_half_tick` when `pre_src` = 1. General reset or power-on reset clears it.
- R10: A write with `wr_en` updates only the bytes whose enables are set. `wr_be[1:0]` select bytes 1:0 of the low period (`wr_data[15:0]`), and `wr_be[3:2]` select bytes 1:0 of the high period (`wr_data[31:16]`). Both words can be written at once as one 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears counters and periods |
| rst_n | input | 1 | General reset, active low; counters untouched |
| sys_half_tick | input | 1 | One-cycle enable at system clock/2 rate |
| ref_half_tick | input | 1 | One-cycle enable at reference clock/2 rate |
| pre_src | input | 1 | Prescaler input select (0 system, 1 reference) |
| clk_sel | input | 3 | Tick source select |
| chain_en | input | 1 | Couple both words into one 32-bit counter |
| irq_en | input | 1 | Interrupt enable |
| irq_lvl | input | 3 | Interrupt level; 0 masks the request |
| wr_en | input | 1 | Period write strobe |
| wr_be | input | 4 | Byte enables for the two period words |
| wr_data | input | 32 | Write data {high period, low period} |
| flag_clr | input | 1 | Write-one-to-clear pulse for the zero flag |
| count_o | output | 32 | Counter value {upper word, low word} |
| zero_flag_o | output | 1 | Sticky zero flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A write is taken at one rising edge, and the next rising edge performs the load, so the loaded value is visible two edges after the write cycle begins. A tick counts at the same edge that samples it, and `count_o` and `zero_flag_o` update at that edge. `irq_o` follows the flag combinationally. The bench changes inputs on falling edges and compares on the following falling edge, so each check sits one half period after the edge that produced its result. The clock-select sweep first applies a general reset, so the prescaler starts from 0 and the expected count is exactly the number of source pulses divided by the tap ratio.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } rtc_state_e;

    localparam logic [2:0] SEL_SYS   = 3'b000;
    localparam logic [2:0] SEL_REF   = 3'b001;
    localparam logic [2:0] SEL_P1024 = 3'b010;
    localparam logic [2:0] SEL_P256  = 3'b011;
    localparam logic [2:0] SEL_P64   = 3'b100;
    localparam logic [2:0] SEL_P16   = 3'b101;

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_all_n,
    input  logic       sys_half_tick,
    input  logic       ref_half_tick,
    input  logic       pre_src,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    import rtc_pkg::*;

    localparam int NTAP = 4;

    logic             pre_pulse;
    logic [PRE_W-1:0] pre_cnt;
    logic [NTAP-1:0]  tap_en;   // [0] /16, [1] /64, [2] /256, [3] /1024

    assign pre_pulse = pre_src ? ref_half_tick : sys_half_tick;

    always_ff @(posedge clk) begin
        if (!rst_all_n)
            pre_cnt <= '0;
        else if (pre_pulse)
            pre_cnt <= pre_cnt + 1'b1;
    end

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            localparam int TB = 4 + 2 * g;
            assign tap_en[g] = pre_pulse && (&pre_cnt[TB-1:0]);
        end
    endgenerate

    always_comb begin
        unique case (clk_sel)
            SEL_SYS:   tick = sys_half_tick;
            SEL_REF:   tick = ref_half_tick;
            SEL_P1024: tick = tap_en[3];
            SEL_P256:  tick = tap_en[2];
            SEL_P64:   tick = tap_en[1];
            SEL_P16:   tick = tap_en[0];
            default:   tick = 1'b0;
        endcase
    end

    // R8: the two stop encodings produce no tick
    assert_stop_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_all_n)
        (clk_sel[2:1] == 2'b11) |-> !tick);

    // R9: a /16 enable is followed by the low prescaler nibble wrapping to zero
    assert_prescale_wrap_R9: assert property (@(posedge clk) disable iff (!rst_all_n)
        tap_en[0] |=> (pre_cnt[3:0] == 4'h0));

endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm (
    input  logic clk,
    input  logic rst_all_n,
    input  logic arm_wr,
    output logic load_o,
    output logic run_o
);
    import rtc_pkg::*;

    rtc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_all_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (arm_wr) state_d = ST_LOAD;                 // ARM
            ST_LOAD: state_d = arm_wr ? ST_LOAD : ST_RUN;           // START
            ST_RUN:  if (arm_wr) state_d = ST_LOAD;                 // REARM
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: load_o = 1'b1;
            ST_RUN:  run_o  = 1'b1;
            default: ;
        endcase
    end

    // R3: an arming write always leads to a load cycle next
    assert_arm_loads_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
        arm_wr |=> load_o);

    // R3: a run cycle is preceded by a load or run cycle
    assert_run_after_load_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(run_o) |-> $past(load_o));

endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int WORD_W = 16,
    localparam int BPW   = WORD_W / 8
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_all_n,
    input  logic                wr_en,
    input  logic [2*BPW-1:0]    wr_be,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic                chain_en,
    input  logic                load,
    input  logic                run,
    input  logic                tick,
    input  logic                flag_clr,
    output logic [WORD_W-1:0]   lo_o,
    output logic [WORD_W-1:0]   hi_o,
    output logic                zero_flag_o
);
    logic [WORD_W-1:0] lo_per_q, hi_per_q;
    logic [WORD_W-1:0] lo_q, hi_q, lo_d, hi_d;
    logic              step, hit, flag_q;

    // period words: byte-lane writes, power-on reset only
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lo_per_q <= '0;
            hi_per_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < BPW; b++) begin
                if (wr_be[b])
                    lo_per_q[8*b +: 8] <= wr_data[8*b +: 8];
                if (wr_be[BPW+b])
                    hi_per_q[8*b +: 8] <= wr_data[WORD_W + 8*b +: 8];
            end
        end
    end

    assign step = run && tick;

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (load) begin
            lo_d = lo_per_q;
            if (chain_en)
                hi_d = hi_per_q;
        end else if (step) begin
            if (lo_q == '0) begin
                if (chain_en) begin
                    lo_d = '1;
                    hi_d = hi_q - 1'b1;
                end else begin
                    lo_d = lo_per_q;
                end
            end else begin
                lo_d = lo_q - 1'b1;
            end
        end
    end

    assign hit = step && (lo_d == '0);

    // counters survive general reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_all_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    assign lo_o        = lo_q;
    assign hi_o        = hi_q;
    assign zero_flag_o = flag_q;

    // R5: chained wrap borrows from the upper word
    assert_chain_wrap_R5: assert property (@(posedge clk) disable iff (!por_n)
        (step && !load && chain_en && lo_q == '0) |=>
            (lo_q == '1) && (hi_q == $past(hi_q - 1'b1)));

    // R4: unchained zero reloads the low period
    assert_reload_R4: assert property (@(posedge clk) disable iff (!por_n)
        (step && !load && !chain_en && lo_q == '0) |=> (lo_q == $past(lo_per_q)));

    // R2: without load or counted tick the count does not move
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!load && !step) |=> ($stable(lo_q) && $stable(hi_q)));

    // R6: the flag only rises after a counted tick
    assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        $rose(flag_q) |-> $past(step));

endmodule

// File: rtl/chain_rtc_timer.sv
module chain_rtc_timer #(
    parameter int WORD_W = 16,
    parameter int PRE_W  = 10,
    localparam int BE_W  = 2 * (WORD_W / 8)
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                sys_half_tick,
    input  logic                ref_half_tick,
    input  logic                pre_src,
    input  logic [2:0]          clk_sel,
    input  logic                chain_en,
    input  logic                irq_en,
    input  logic [2:0]          irq_lvl,
    input  logic                wr_en,
    input  logic [BE_W-1:0]     wr_be,
    input  logic [2*WORD_W-1:0] wr_data,
    input  logic                flag_clr,
    output logic [2*WORD_W-1:0] count_o,
    output logic                zero_flag_o,
    output logic                irq_o
);
    logic rst_all_n;
    logic tick, arm_wr, load, run;
    logic [WORD_W-1:0] lo_w, hi_w;

    assign rst_all_n = por_n && rst_n;
    assign arm_wr    = wr_en && wr_be[0];

    rtc_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk           (clk),
        .rst_all_n     (rst_all_n),
        .sys_half_tick (sys_half_tick),
        .ref_half_tick (ref_half_tick),
        .pre_src       (pre_src),
        .clk_sel       (clk_sel),
        .tick          (tick)
    );

    rtc_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_all_n (rst_all_n),
        .arm_wr    (arm_wr),
        .load_o    (load),
        .run_o     (run)
    );

    rtc_count_core #(.WORD_W(WORD_W)) u_core (
        .clk         (clk),
        .por_n       (por_n),
        .rst_all_n   (rst_all_n),
        .wr_en       (wr_en),
        .wr_be       (wr_be),
        .wr_data     (wr_data),
        .chain_en    (chain_en),
        .load        (load),
        .run         (run),
        .tick        (tick),
        .flag_clr    (flag_clr),
        .lo_o        (lo_w),
        .hi_o        (hi_w),
        .zero_flag_o (zero_flag_o)
    );

    assign count_o = {hi_w, lo_w};
    assign irq_o   = zero_flag_o && irq_en && (irq_lvl != 3'd0);

    // R1: power-on reset leaves the count at zero
    assert_por_zero_R1: assert property (@(posedge clk)
        !por_n |=> (count_o == '0));

endmodule

// File: tb/tb_chain_rtc_timer.sv
module tb_chain_rtc_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n, rst_n, sys_half_tick, ref_half_tick, pre_src;
    logic [2:0]  clk_sel, irq_lvl;
    logic        chain_en, irq_en, wr_en, flag_clr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data, count_o;
    logic        zero_flag_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_rtc_timer dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .sys_half_tick(sys_half_tick), .ref_half_tick(ref_half_tick),
        .pre_src(pre_src), .clk_sel(clk_sel), .chain_en(chain_en),
        .irq_en(irq_en), .irq_lvl(irq_lvl), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .flag_clr(flag_clr), .count_o(count_o),
        .zero_flag_o(zero_flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic one_tick();
        @(negedge clk); sys_half_tick = 1'b1;
        @(negedge clk); sys_half_tick = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] m, keep;
        logic        ef;
        por_n = 0; rst_n = 0; sys_half_tick = 0; ref_half_tick = 0; pre_src = 0;
        clk_sel = 3'b000; irq_lvl = 0; chain_en = 0; irq_en = 0; wr_en = 0;
        flag_clr = 0; wr_be = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;

        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 flag", {31'd0, zero_flag_o}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);

        // R3 no counting before arming
        repeat (3) one_tick();
        chk("R3 unarmed", count_o, 0);
        wr(4'b0010, 32'h0000_0300);
        one_tick();
        chk("R3 lane1 does not arm", count_o, 0);
        // R10 arm with low byte; tick on the load edge ignored (R3)
        wr(4'b0001, 32'h0000_0004);
        sys_half_tick = 1'b1;
        @(negedge clk); sys_half_tick = 1'b0;
        chk("R10 bytes merged / R3 load tick ignored", count_o, 32'h0000_0304);

        // R4 / R6 unchained sweep over small periods
        for (int p = 0; p < 5; p++) begin
            pulse_clr();
            wr(4'b0011, p);
            @(negedge clk);
            chk("R4 load", count_o, p);
            m = p; ef = 1'b0;
            for (int k = 0; k < 12; k++) begin
                one_tick();
                if (m == 0) m = p; else m = m - 1;
                if (m == 0) ef = 1'b1;
                chk("R4 step", count_o, m);
                chk("R6 flag", {31'd0, zero_flag_o}, {31'd0, ef});
            end
        end
        pulse_clr();
        chk("R6 cleared", {31'd0, zero_flag_o}, 0);

        // R6 set wins over clear
        wr(4'b0011, 32'd1);
        @(negedge clk);
        @(negedge clk); sys_half_tick = 1'b1; flag_clr = 1'b1;
        @(negedge clk); sys_half_tick = 1'b0; flag_clr = 1'b0;
        chk("R6 set beats clear", {31'd0, zero_flag_o}, 1);

        // R7 irq gating sweep with flag set
        for (int e = 0; e < 2; e++) begin
            for (int l = 0; l < 8; l++) begin
                @(negedge clk); irq_en = e[0]; irq_lvl = l[2:0];
                @(negedge clk);
                chk("R7 irq", {31'd0, irq_o}, {31'd0, (e != 0 && l != 0)});
            end
        end
        pulse_clr();
        chk("R7 irq after clear", {31'd0, irq_o}, 0);
        irq_en = 0; irq_lvl = 0;

        // R5 chained 32-bit decrement across wraps
        chain_en = 1'b1;
        for (int c = 0; c < 5; c++) begin
            logic [31:0] init;
            case (c)
                0: init = 32'h0000_0002;
                1: init = 32'h0001_0001;
                2: init = 32'h0002_0000;
                3: init = 32'h0000_0000;
                default: init = 32'h8000_0003;
            endcase
            pulse_clr();
            wr(4'hF, init);
            @(negedge clk);
            chk("R5 load", count_o, init);
            m = init; ef = 1'b0;
            for (int k = 0; k < 6; k++) begin
                one_tick();
                m = m - 1;
                if (m[15:0] == 16'h0) ef = 1'b1;
                chk("R5 step", count_o, m);
                chk("R6 chained flag", {31'd0, zero_flag_o}, {31'd0, ef});
            end
        end

        // R2 general reset keeps count, clears flag, stops counting
        wr(4'hF, 32'h0003_0001);
        @(negedge clk);
        one_tick();
        keep = count_o;
        chk("R2 pre", {31'd0, zero_flag_o}, 1);
        pulse_rst();
        chk("R2 count kept", count_o, keep);
        chk("R2 flag cleared", {31'd0, zero_flag_o}, 0);
        one_tick();
        chk("R2 idle after reset", count_o, keep);

        // R8 / R9 tick source sweep
        chain_en = 1'b0;
        for (int sel = 0; sel < 8; sel++) begin
            for (int drv = 0; drv < 2; drv++) begin
                for (int ps = 0; ps < 2; ps++) begin
                    int exp_dec;
                    int divs;
                    clk_sel = sel[2:0];
                    pre_src = ps[0];
                    pulse_rst();
                    wr(4'b0011, 32'h0000_FFFF);
                    @(negedge clk);
                    case (sel)
                        2: divs = 1024;
                        3: divs = 256;
                        4: divs = 64;
                        default: divs = 16;
                    endcase
                    if (sel == 0) exp_dec = (drv == 0) ? 2048 : 0;
                    else if (sel == 1) exp_dec = (drv == 1) ? 2048 : 0;
                    else if (sel <= 5) exp_dec = (ps == drv) ? 2048 / divs : 0;
                    else exp_dec = 0;
                    if (drv == 0) sys_half_tick = 1'b1; else ref_half_tick = 1'b1;
                    repeat (2048) @(negedge clk);
                    sys_half_tick = 1'b0; ref_half_tick = 1'b0;
                    chk((sel >= 2 && sel <= 5) ? "R9 prescaled source" : "R8 direct/stop source",
                        {16'd0, count_o[15:0]}, 32'h0000_FFFF - exp_dec);
                end
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule